// File: doc/BRIEF.md
# Shift-Chain LIFO Stack

This block is a last-in-first-out word store made from a line of registers rather than from a RAM and a stack pointer. Each register cell is wired to its upper and lower neighbour. A push loads the head cell and moves every held word one place deeper. A destructive pop moves every word one place toward the head. A peek reads the head cell and moves nothing. Because every cell moves on each push or pop, the head word is always at cell 0, and the read path is one fixed register with no address decode.

An occupancy counter drives the empty and full outputs. A push on a full stack and a read on an empty stack are refused, and each raises a one-cycle error pulse. Asserting push and pop together swaps the head word in place. Every result appears on the registered outputs in the clock cycle after the request.

Top module: `shift_lifo`

## Requirements
- R1: While reset is held and after it is released, count_o is 0, empty_o is 1, full_o is 0, and rvalid_o, rdata_o, overflow_o and underflow_o are all 0.
- R2: An accepted push (push_i=1, pop_i=0, stack not full) places wdata_i at the head, moves every earlier word one place deeper, and raises count_o by 1 in the next cycle. Later pops return the words in reverse order of their pushes.
- R3: An accepted pop (pop_i=1, push_i=0, stack not empty) puts the head word on rdata_o with rvalid_o=1 in the next cycle, lowers count_o by 1, moves every word one place up, and clears the deepest cell. In a cycle after a request with no read, rvalid_o is 0 and rdata_o is 0.
- R4: A peek (peek_i=1 with neither push_i nor pop_i) puts the head word on rdata_o with rvalid_o=1 in the next cycle. It leaves count_o and the stored words unchanged.
- R5: empty_o is 1 exactly when count_o is 0. full_o is 1 exactly when count_o equals DEPTH. count_o never exceeds DEPTH.
- R6: A push with pop_i=0 on a full stack is refused. In the next cycle overflow_o is 1 for one cycle, count_o stays at DEPTH, and the stored words are unchanged.
- R7: A pop or peek on an empty stack returns rdata_o=0 with rvalid_o=1 and underflow_o=1 in the next cycle, and count_o stays 0.
- R8: Push and pop together on a non-empty stack (full included) replace the head word with wdata_i. The old head word goes to rdata_o with rvalid_o=1 in the next cycle. No word moves, and count_o is unchanged.
- R9: Push and pop together on an empty stack store wdata_i as the only word (count_o becomes 1). The read part returns rdata_o=0 with rvalid_o=1 and underflow_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Destructive read request |
| peek_i | input | 1 | Non-destructive read request |
| wdata_i | input | DATA_W | Word to push |
| rdata_o | output | DATA_W | Word read, valid with rvalid_o |
| rvalid_o | output | 1 | Read result is present this cycle |
| overflow_o | output | 1 | One-cycle pulse: push refused on a full stack |
| underflow_o | output | 1 | One-cycle pulse: read on an empty stack |
| count_o | output | $clog2(DEPTH+1) | Number of stored words |
| empty_o | output | 1 | Stack holds no word |
| full_o | output | 1 | Stack holds DEPTH words |

## Verification
A word that sits in the wrong cell does not show up at once. It shows up on the pop that brings it to the head, so it can appear as many cycles after the fault as there are words above it. The bench therefore fills the stack to the limit and drains it completely, which exposes every cell position. A counter that drifts from the cell contents shows first on empty_o or full_o. It then shows on a wrong underflow or overflow pulse, or on a read of zero where a word was expected. The comparisons run every cycle, so such faults are caught on the cycle after the request that reveals them.

// File: rtl/lifo_pkg.sv
package lifo_pkg;

    // Movement applied to every cell of the chain in one cycle
    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,   // nothing moves
        MV_DOWN = 2'd1,   // each word goes one cell deeper, head takes new word
        MV_UP   = 2'd2,   // each word goes one cell toward the head
        MV_LOAD = 2'd3    // only the head cell is overwritten
    } move_e;

endpackage

// File: rtl/lifo_cell.sv
module lifo_cell
    import lifo_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter bit IS_HEAD = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  move_e             move_i,
    input  logic [DATA_W-1:0] above_i,
    input  logic [DATA_W-1:0] below_i,
    output logic [DATA_W-1:0] word_o
);

    logic [DATA_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        case (move_i)
            MV_DOWN: word_d = above_i;
            MV_UP:   word_d = below_i;
            MV_LOAD: word_d = IS_HEAD ? above_i : word_q;
            default: word_d = word_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word_o = word_q;

endmodule

// File: rtl/lifo_count.sv
module lifo_count #(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] count_o,
    output logic             empty_o,
    output logic             full_o
);

    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH);

    logic [CNT_W-1:0] count_d, count_q;

    always_comb begin
        count_d = count_q;
        if (inc_i && !dec_i)      count_d = count_q + 1'b1;
        else if (dec_i && !inc_i) count_d = count_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_d;
    end

    assign count_o = count_q;
    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == LIMIT);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LIMIT); // R5

endmodule

// File: rtl/shift_lifo.sv
module shift_lifo
    import lifo_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic              peek_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o,
    output logic              overflow_o,
    output logic              underflow_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              empty_o,
    output logic              full_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              ovf;
        logic              udf;
    } out_t;

    out_t  out_d, out_q;
    move_e move;
    logic  push_ok, pop_ok, swap, rd_req;
    logic  empty, full;

    logic [DATA_W-1:0] cell_q [DEPTH];

    // Request decode and registered result
    always_comb begin
        rd_req  = pop_i || peek_i;
        swap    = push_i && pop_i && !empty;
        push_ok = push_i && !full && !(pop_i && !empty);
        pop_ok  = pop_i && !push_i && !empty;

        if (swap)         move = MV_LOAD;
        else if (push_ok) move = MV_DOWN;
        else if (pop_ok)  move = MV_UP;
        else              move = MV_HOLD;

        out_d        = '0;
        out_d.rvalid = rd_req;
        out_d.rdata  = (rd_req && !empty) ? cell_q[0] : '0;
        out_d.ovf    = push_i && !pop_i && full;
        out_d.udf    = rd_req && empty;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    // Register chain
    for (genvar k = 0; k < DEPTH; k++) begin : g_chain
        logic [DATA_W-1:0] above, below;
        if (k == 0) begin : g_head
            assign above = wdata_i;
        end else begin : g_mid_up
            assign above = cell_q[k-1];
        end
        if (k == DEPTH - 1) begin : g_tail
            assign below = '0;
        end else begin : g_mid_dn
            assign below = cell_q[k+1];
        end
        lifo_cell #(
            .DATA_W  (DATA_W),
            .IS_HEAD (k == 0)
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .move_i  (move),
            .above_i (above),
            .below_i (below),
            .word_o  (cell_q[k])
        );
    end

    lifo_count #(
        .DEPTH (DEPTH)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (push_ok),
        .dec_i   (pop_ok),
        .count_o (count_o),
        .empty_o (empty),
        .full_o  (full)
    );

    assign empty_o     = empty;
    assign full_o      = full;
    assign rdata_o     = out_q.rdata;
    assign rvalid_o    = out_q.rvalid;
    assign overflow_o  = out_q.ovf;
    assign underflow_o = out_q.udf;

    AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !full_o) |=> (cell_q[0] == $past(wdata_i))); // R2
    AST_BOTTOM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> (cell_q[DEPTH-1] == '0)); // R3
    AST_PEEK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (peek_i && !push_i && !pop_i) |=> $stable(count_o)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && full_o) |=> (overflow_o && full_o)); // R6
    AST_UDF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_o |-> (rdata_o == '0 && rvalid_o)); // R7
    AST_SWAP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && !empty_o) |=> $stable(count_o)); // R8

endmodule

// File: tb/sim_shift_lifo.sv
module sim_shift_lifo;

    localparam int DW  = 16;
    localparam int DEP = 8;
    localparam int CW  = $clog2(DEP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          push_i = 1'b0, pop_i = 1'b0, peek_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o, overflow_o, underflow_o, empty_o, full_o;
    logic [CW-1:0] count_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    shift_lifo #(.DATA_W(DW), .DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .peek_i(peek_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
        .rvalid_o(rvalid_o), .overflow_o(overflow_o),
        .underflow_o(underflow_o), .count_o(count_o),
        .empty_o(empty_o), .full_o(full_o)
    );

    typedef struct {
        logic          rv;
        logic [DW-1:0] rd;
        logic          ov;
        logic          ud;
        int            cnt;
        string         tag;
    } exp_t;

    exp_t          exp_q[$];
    logic [DW-1:0] model[$];   // index 0 is the head

    // Driver: applies one request and queues the expected result
    task automatic op(input bit pu, input bit po, input bit pk,
                      input logic [DW-1:0] w, input string tag);
        exp_t e;
        @(negedge clk);
        push_i = pu; pop_i = po; peek_i = pk; wdata_i = w;
        e.rv = po || pk; e.rd = '0; e.ov = 1'b0; e.ud = 1'b0; e.tag = tag;
        if ((po || pk) && model.size() == 0) e.ud = 1'b1;
        else if (po || pk) e.rd = model[0];
        if (pu && po) begin
            if (model.size() == 0) model.push_front(w);
            else model[0] = w;
        end else if (pu) begin
            if (model.size() == DEP) e.ov = 1'b1;
            else model.push_front(w);
        end else if (po) begin
            if (model.size() != 0) void'(model.pop_front());
        end
        e.cnt = model.size();
        @(posedge clk);
        #1;
        exp_q.push_back(e);
    endtask

    // Monitor: compares each queued expectation with the outputs
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (rvalid_o !== e.rv || rdata_o !== e.rd || overflow_o !== e.ov ||
                    underflow_o !== e.ud || int'(count_o) != e.cnt ||
                    empty_o !== (e.cnt == 0) || full_o !== (e.cnt == DEP)) begin
                    failures++;
                    $display("FAIL %s: got rv=%0b rd=%h ov=%0b ud=%0b cnt=%0d em=%0b fu=%0b exp rv=%0b rd=%h ov=%0b ud=%0b cnt=%0d",
                             e.tag, rvalid_o, rdata_o, overflow_o, underflow_o, count_o,
                             empty_o, full_o, e.rv, e.rd, e.ov, e.ud, e.cnt);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] lf;
        lf = 16'hACE1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R1 during reset
        if (count_o !== '0 || empty_o !== 1'b1 || full_o !== 1'b0 || rvalid_o !== 1'b0 ||
            overflow_o !== 1'b0 || underflow_o !== 1'b0 || rdata_o !== '0) begin
            failures++;
            $display("FAIL R1: got cnt=%0d em=%0b fu=%0b rv=%0b exp cnt=0 em=1 fu=0 rv=0",
                     count_o, empty_o, full_o, rvalid_o);
        end
        rst_n = 1'b1;
        op(0, 0, 0, '0, "R1");
        // Fill to the limit (R2, R5)
        for (int i = 0; i < DEP; i++) op(1, 0, 0, DW'(16'h1100 + i), "R2");
        op(0, 0, 1, '0, "R4");
        op(1, 0, 0, 16'hDEAD, "R6");
        op(1, 0, 1, 16'hBEEF, "R6");
        op(0, 0, 1, '0, "R4");
        op(1, 1, 0, 16'h5A5A, "R8");
        op(0, 0, 0, '0, "R5");
        // Drain completely (R3)
        for (int i = 0; i < DEP; i++) op(0, 1, 0, '0, "R3");
        op(0, 1, 0, '0, "R7");
        op(0, 0, 1, '0, "R7");
        op(1, 1, 0, 16'h7777, "R9");
        op(0, 0, 1, '0, "R9");
        op(0, 1, 0, '0, "R9");
        // Partial depth, swap and peek mixed (R2, R3, R8)
        op(1, 0, 0, 16'h0001, "R2");
        op(1, 0, 0, 16'h0002, "R2");
        op(1, 1, 0, 16'h0003, "R8");
        op(1, 0, 1, 16'h0004, "R4");
        op(0, 1, 0, '0, "R3");
        op(0, 1, 0, '0, "R3");
        op(0, 1, 0, '0, "R3");
        op(0, 1, 0, '0, "R7");
        // Pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op(lf[0], lf[1] & lf[5], lf[2] & lf[3], lf ^ 16'h3C3C, "R2");
        end
        op(0, 0, 0, '0, "R5");
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R3: got pending=%0d exp 0", exp_q.size());
        end
        finish_run();
    end

endmodule